// File: doc/BRIEF.md
# Configurable Binary Crossbar Switch

This block is a configurable binary crossbar that routes a set of active row lines onto a set of column outputs. Each crosspoint is a single stored bit. When a row line is driven and its crosspoint in a given column holds a 1, that column output goes high. It serves as the local transition switch of a state-matching engine: the input vector marks which rows are active, and the output vector marks which columns those rows reach. One extra column per row holds an acceptance flag, and a separate output reports the combined acceptance result.

The block has two modes, chosen by the configuration write enable. With the enable high, the block is in configuration mode: a row address, a chunk index and a data word write one slice of a row. A row is filled over several cycles, one chunk per cycle. With the enable low, the block is in operational mode: an input vector is accepted through a valid/ready handshake. The block evaluates the OR-of-ANDs of that vector with every column and registers the result. The result leaves through a second valid/ready handshake.

Back-pressure works as follows. The input side accepts a vector only when the configuration write enable is low and the single result register is empty or is being drained in the same cycle. While a result is held with the output ready low, that result stays stable and no new vector is taken. If a vector is offered while a configuration write is in progress, the write wins, the vector is not taken, and a clash flag is raised for one cycle.

Top module: `xbar_switch`

## Requirements
- R1: After reset, the result valid output and the clash flag are 0, the input ready output is 1, and every stored crosspoint, including the acceptance column, reads as 0.
- R2: With cfg_we high and cfg_row below ROWS, each bit of cfg_data is written to row cfg_row, columns cfg_chunk*CHUNK+i, for i from 0 to CHUNK-1. A data bit of 1 sets the crosspoint and a data bit of 0 clears it. Bit i of cfg_data maps to column cfg_chunk*CHUNK+i.
- R3: A configuration write leaves unchanged all columns outside the selected chunk and all other rows.
- R4: A full row of COLS bits is written by NCH = COLS/CHUNK writes, one for each chunk index, in any order. The row then holds the union of those writes.
- R5: When in_valid and in_ready are both high at a clock edge, out_valid is high after that edge. out_col bit c then equals the OR over all rows r of in_vec[r] AND cell[r][c], and any number of rows may be driven at once.
- R6: The acceptance bit of a row is written from cfg_acc only by a write whose chunk index is NCH-1. out_acc is the OR over all rows r of in_vec[r] AND accept[r].
- R7: While cfg_we is high, in_ready is 0 and no vector is taken. If in_valid is high in such a cycle, clash is 1 in the following cycle, and otherwise clash is 0.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_col and out_acc stay stable, and in_ready is 0.
- R9: An all-zero input vector yields an all-zero out_col and an out_acc of 0.
- R10: A write with cfg_row of ROWS or above changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | 1 selects configuration mode, 0 selects operational mode |
| cfg_row | input | RW = clog2(ROWS) | Row to write |
| cfg_chunk | input | CW = clog2(COLS/CHUNK) | Column chunk index |
| cfg_data | input | CHUNK | Bit values for the selected chunk |
| cfg_acc | input | 1 | Acceptance bit, stored when the chunk index is the last one |
| in_valid | input | 1 | Input vector offered |
| in_ready | output | 1 | Input vector taken at this edge when in_valid is high |
| in_vec | input | ROWS | Active row lines |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream takes the result |
| out_col | output | COLS | Column result vector |
| out_acc | output | 1 | Acceptance result |
| clash | output | 1 | A vector was offered during a write in the previous cycle |

## Verification
A configuration write and an evaluation request can fall in the same cycle. The bench provokes this by raising cfg_we and in_valid together. It then judges at the ports that in_ready was low, that clash rises on the next cycle while out_valid stays low, and that a read of the row shows the write landed. A second overlap is tested with out_ready held low: a held result must remain stable while a new vector waits.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    XB_IDLE  = 2'd0,
    XB_WRITE = 2'd1,
    XB_READ  = 2'd2,
    XB_CLASH = 2'd3
  } xb_op_e;

  function automatic int chunk_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_mode_dec.sv
module xbar_mode_dec
  import xbar_pkg::*;
(
  input  logic   we,
  input  logic   rd_req,
  output xb_op_e op,
  output logic   wr_go,
  output logic   rd_try,
  output logic   clash_now
);
  always_comb begin
    if (we)          op = rd_req ? XB_CLASH : XB_WRITE;
    else if (rd_req) op = XB_READ;
    else             op = XB_IDLE;
  end

  assign wr_go     = (op == XB_WRITE) || (op == XB_CLASH);
  assign rd_try    = (op == XB_READ);
  assign clash_now = (op == XB_CLASH);
endmodule

// File: rtl/xbar_cell_store.sv
module xbar_cell_store #(
  parameter int ROWS  = 280,
  parameter int COLS  = 256,
  parameter int CHUNK = 64,
  localparam int NCH  = COLS / CHUNK,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = xbar_pkg::chunk_bits(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_go,
  input  logic [RW-1:0]              row,
  input  logic [CW-1:0]              chunk,
  input  logic [CHUNK-1:0]           data,
  input  logic                       acc_in,
  output logic [ROWS-1:0][COLS-1:0]  cells,
  output logic [ROWS-1:0]            acc_bits
);
  logic [ROWS-1:0] row_hit;
  logic [NCH-1:0]  chunk_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_rsel
    assign row_hit[r] = wr_go && (row == RW'(r));
  end
  for (genvar k = 0; k < NCH; k++) begin : g_csel
    assign chunk_hit[k] = (chunk == CW'(k));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar k = 0; k < NCH; k++) begin : g_chunk
      always_ff @(posedge clk) begin
        if (!rst_n)
          cells[r][k*CHUNK +: CHUNK] <= '0;
        else if (row_hit[r] && chunk_hit[k])
          cells[r][k*CHUNK +: CHUNK] <= data;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        acc_bits[r] <= 1'b0;
      else if (row_hit[r] && chunk_hit[NCH-1])
        acc_bits[r] <= acc_in;
    end
  end
endmodule

// File: rtl/xbar_or_eval.sv
module xbar_or_eval #(
  parameter int ROWS = 280,
  parameter int COLS = 256
) (
  input  logic [ROWS-1:0]           vec,
  input  logic [ROWS-1:0][COLS-1:0] cells,
  input  logic [ROWS-1:0]           acc_bits,
  output logic [COLS-1:0]           follow,
  output logic                      acc_hit
);
  always_comb begin
    follow = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (vec[r]) follow = follow | cells[r];
    end
  end

  assign acc_hit = |(vec & acc_bits);
endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage #(
  parameter int COLS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [COLS-1:0] col_d,
  input  logic            acc_d,
  input  logic            drain,
  input  logic            clash_d,
  output logic            vld,
  output logic [COLS-1:0] col_q,
  output logic            acc_q,
  output logic            clash_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      col_q   <= '0;
      acc_q   <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      clash_q <= clash_d;
      if (load) begin
        vld   <= 1'b1;
        col_q <= col_d;
        acc_q <= acc_d;
      end else if (drain) begin
        vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int ROWS  = 280,
  parameter int COLS  = 256,
  parameter int CHUNK = 64,
  localparam int NCH  = COLS / CHUNK,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = xbar_pkg::chunk_bits(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RW-1:0]    cfg_row,
  input  logic [CW-1:0]    cfg_chunk,
  input  logic [CHUNK-1:0] cfg_data,
  input  logic             cfg_acc,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ROWS-1:0]  in_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COLS-1:0]  out_col,
  output logic             out_acc,
  output logic             clash
);
  import xbar_pkg::*;

  xb_op_e                    op;
  logic                      wr_go, rd_try, clash_now;
  logic [ROWS-1:0][COLS-1:0] cells;
  logic [ROWS-1:0]           acc_bits;
  logic [COLS-1:0]           follow;
  logic                      acc_hit;
  logic                      take;

  xbar_mode_dec u_dec (
    .we        (cfg_we),
    .rd_req    (in_valid),
    .op        (op),
    .wr_go     (wr_go),
    .rd_try    (rd_try),
    .clash_now (clash_now)
  );

  xbar_cell_store #(.ROWS(ROWS), .COLS(COLS), .CHUNK(CHUNK)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .row      (cfg_row),
    .chunk    (cfg_chunk),
    .data     (cfg_data),
    .acc_in   (cfg_acc),
    .cells    (cells),
    .acc_bits (acc_bits)
  );

  xbar_or_eval #(.ROWS(ROWS), .COLS(COLS)) u_eval (
    .vec      (in_vec),
    .cells    (cells),
    .acc_bits (acc_bits),
    .follow   (follow),
    .acc_hit  (acc_hit)
  );

  assign in_ready = !cfg_we && (!out_valid || out_ready);
  assign take     = rd_try && in_ready;

  xbar_out_stage #(.COLS(COLS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .col_d   (follow),
    .acc_d   (acc_hit),
    .drain   (out_ready),
    .clash_d (clash_now),
    .vld     (out_valid),
    .col_q   (out_col),
    .acc_q   (out_acc),
    .clash_q (clash)
  );
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
  parameter int ROWS = 280,
  parameter int COLS = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [COLS-1:0] out_col,
  input logic            out_acc,
  input logic            clash
);
  assert_take_gives_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_result_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_write_blocks_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_ready);

  assert_clash_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_valid) |=> clash);

  assert_clash_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> $past(cfg_we && in_valid));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_acc)));

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind xbar_switch xbar_switch_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_col   (out_col),
  .out_acc   (out_acc),
  .clash     (clash)
);

// File: tb/sim_xbar_switch.sv
module sim_xbar_switch;
  localparam int ROWS  = 280;
  localparam int COLS  = 256;
  localparam int CHUNK = 64;
  localparam int NCH   = COLS / CHUNK;
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(NCH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [RW-1:0]    cfg_row = '0;
  logic [CW-1:0]    cfg_chunk = '0;
  logic [CHUNK-1:0] cfg_data = '0;
  logic             cfg_acc = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [ROWS-1:0]  in_vec = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [COLS-1:0]  out_col;
  logic             out_acc;
  logic             clash;

  always #10 clk = ~clk;

  xbar_switch #(.ROWS(ROWS), .COLS(COLS), .CHUNK(CHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_chunk(cfg_chunk), .cfg_data(cfg_data), .cfg_acc(cfg_acc),
    .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_acc(out_acc), .clash(clash)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [COLS-1:0] mdl [ROWS];
  logic            macc [ROWS];
  logic [COLS:0]   sb_q [$];
  string           sb_tag [$];

  task automatic check(input string req, input logic [COLS:0] act, input logic [COLS:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [COLS:0] expect_of(input logic [ROWS-1:0] v);
    logic [COLS-1:0] c = '0;
    logic a = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (v[r]) begin
        c = c | mdl[r];
        a = a | macc[r];
      end
    end
    return {a, c};
  endfunction

  task automatic do_write(input int row, input int chunk, input logic [CHUNK-1:0] d, input logic a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = RW'(row); cfg_chunk = CW'(chunk); cfg_data = d; cfg_acc = a;
    if (row < ROWS) begin
      mdl[row][chunk*CHUNK +: CHUNK] = d;
      if (chunk == NCH-1) macc[row] = a;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [ROWS-1:0] v, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb_q.push_back(expect_of(v));
    sb_tag.push_back(req);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: result consumed at the next edge when valid and ready
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        check("R5 unexpected result", 1'b1, 1'b0);
      end else begin
        string t = sb_tag.pop_front();
        check(t, {out_acc, out_col}, sb_q.pop_front());
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++) begin mdl[r] = '0; macc[r] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 clash", clash, 0);
    check("R1 in_ready", in_ready, 1);
    do_read('1, "R1 cleared array");

    // R2: set bits in chunk 0 of row 5
    do_write(5, 0, 64'hF0F0_1234_0000_00FF, 1'b0);
    v = '0; v[5] = 1'b1;
    do_read(v, "R2 chunk write");
    // R3: other chunk of same row, chunk 0 kept
    do_write(5, 2, 64'hDEAD_BEEF_CAFE_0001, 1'b0);
    do_read(v, "R3 untouched chunk");
    // R2: zeros clear
    do_write(5, 0, 64'h0000_0000_0000_000F, 1'b0);
    do_read(v, "R2 clear bits");

    // R4 / R6: full row over four writes, out of order
    do_write(ROWS-1, 3, 64'h8000_0000_0000_0001, 1'b1);
    do_write(ROWS-1, 1, 64'h0123_4567_89AB_CDEF, 1'b0);
    do_write(ROWS-1, 0, 64'hFFFF_0000_FFFF_0000, 1'b0);
    do_write(ROWS-1, 2, 64'h5555_AAAA_5555_AAAA, 1'b0);
    v = '0; v[ROWS-1] = 1'b1;
    do_read(v, "R4 full row");
    do_read(v, "R6 accept column");
    // R6: acceptance only on last chunk; write chunk 1 with acc=0 must keep it
    do_write(ROWS-1, 1, 64'h0123_4567_89AB_CDEF, 1'b0);
    do_read(v, "R6 acc kept by other chunk");

    // R5: multi-row OR
    do_write(10, 3, 64'h0000_0000_FFFF_0000, 1'b0);
    v = '0; v[5] = 1'b1; v[10] = 1'b1; v[ROWS-1] = 1'b1;
    do_read(v, "R5 multi row");

    // R10: out-of-range row is ignored
    do_write(300, 0, '1, 1'b1);
    do_write(511, 3, '1, 1'b1);
    do_read('1, "R10 out of range row");

    // R9: zero vector
    do_read('0, "R9 zero vector");

    // R7: write and read in same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = RW'(20); cfg_chunk = CW'(1); cfg_data = 64'h00FF_00FF_00FF_00FF; cfg_acc = 1'b0;
    mdl[20][CHUNK +: CHUNK] = 64'h00FF_00FF_00FF_00FF;
    in_valid = 1'b1; in_vec = '1;
    #1;
    check("R7 ready low during write", in_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    #1;
    check("R7 clash raised", clash, 1);
    check("R7 no result", out_valid, 0);
    @(negedge clk); #1;
    check("R7 clash drops", clash, 0);
    v = '0; v[20] = 1'b1;
    do_read(v, "R7 write landed");

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    v = '0; v[5] = 1'b1;
    do_read(v, "R8 held result");
    repeat (3) @(negedge clk);
    #1;
    check("R8 valid held", out_valid, 1);
    check("R8 ready low", in_ready, 0);
    check("R8 data stable", {out_acc, out_col}, expect_of(v));
    @(negedge clk);
    out_ready = 1'b1;
    v = '0; v[10] = 1'b1;
    do_read(v, "R8 after release");

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [ROWS-1:0] rv;
      do_write($urandom % ROWS, $urandom % NCH, {$urandom, $urandom}, 1'($urandom));
      for (int r = 0; r < ROWS; r++) rv[r] = (($urandom % 16) == 0);
      do_read(rv, "R5 random");
    end

    repeat (4) @(negedge clk);
    check("R5 queue drained", 1'(sb_q.size() == 0), 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule